// File: doc/BRIEF.md
# LAM-Driven Station Scan Controller

This block reads out a crate autonomously. After one start pulse it walks the crate stations from the highest number down to the lowest. For every station whose Look-At-Me request is pending, it asks a single-cycle dataway engine for one read word. Each returned word goes downstream with the number of the station it came from. One walk over all stations is a pass. When a pass finds a pending station, a new pass starts again from the top. The block stops only when a whole pass finds nothing pending, and then raises a one-cycle end-of-block pulse.

The station requests arrive as a vector with one bit per station. The vector is resynchronised through two flip-flop stages before the scan uses it. After a read completes, the scan carries on with the next lower station and does not restart at the top. Within each pass, higher station numbers are therefore served first. A parameter caps the number of passes that find work. A crate that never goes quiet is then abandoned with a timeout flag instead of an end-of-block pulse.

Top module: `lamscan_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `rd_req`, `out_valid`, `eob_irq` and `timeout` are all low.
- R2: A `start` pulse in idle begins a scan at station NUM_STATIONS (23) that walks downward to station 1. Within one pass, words leave in strictly descending station order.
- R3: Each read is requested only for a station whose request is pending. `rd_req` stays high with `rd_stn` stable until the cycle in which `rd_done` is high. Each station is read exactly once in every pass in which it is pending.
- R4: One cycle after the edge that sees `rd_req` and `rd_done` both high, `out_valid` is high for one cycle. In that cycle `out_data` equals the `rd_data` of that handshake and `out_stn` equals the station that was read.
- R5: After a station is serviced, the next station examined is the next lower one, and the stations above it are not revisited in that pass. After station 1, a pass that found work restarts at station NUM_STATIONS.
- R6: A pass that finds no pending station ends the scan: `busy` falls and `eob_irq` is high for exactly one cycle with `timeout` low.
- R7: When MAX_PASSES (16) consecutive passes have each found work, the scan ends after the last of them. `timeout` then goes high and stays high until the next start, and no `eob_irq` is raised.
- R8: Station s is requested by `lam_i[s-1]`. The bits pass a two-stage synchronizer, so a request raised in the same cycle that `start` is accepted is not yet seen when station NUM_STATIONS is examined.
- R9: A `start` pulse while `busy` is high is ignored, and the scan in progress continues unchanged.
- R10: The scan examines one station per clock. With no request pending, `eob_irq` is high in the cycle that follows the NUM_STATIONS-th edge after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (accepted only when idle) |
| lam_i | input | NUM_STATIONS | Per-station request, bit s-1 for station s, asynchronous |
| rd_req | output | 1 | Read request to the dataway engine |
| rd_stn | output | STN_W | Station number to be read |
| rd_done | input | 1 | Engine completion strobe, one cycle |
| rd_data | input | DATA_W | Word returned by the engine with `rd_done` |
| out_valid | output | 1 | Output word valid, one cycle |
| out_data | output | DATA_W | Word read from the station |
| out_stn | output | STN_W | Station the word came from |
| busy | output | 1 | Scan in progress |
| eob_irq | output | 1 | End-of-block pulse after an empty pass |
| timeout | output | 1 | Scan abandoned at the pass limit |

## Verification
Each station is given a number of words to deliver, and its request stays up until that many reads have been made from it. The expected word order is therefore a list of passes: each pass holds, in descending order, the stations that still have words. Random word counts mixed with engine delays of zero to three cycles test ordering and resuming against handshake timing. A lone station 1 tests the wrap from the bottom of a pass. A full crate tests back-to-back reads. Counts of 15 and 16 on one station separate normal end from timeout. An empty crate fixes the per-station scan rate. A request raised together with start shows the synchronizer delay, and a second start in the middle of a scan must leave the word order untouched.

// File: rtl/lamscan_pkg.sv
package lamscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_READ = 2'd2
  } scan_state_e;

endpackage

// File: rtl/lamscan_sync.sv
module lamscan_sync #(
  parameter int WIDTH  = 23,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lamscan_pass_ctrl.sv
module lamscan_pass_ctrl #(
  parameter  int MAX_PASSES = 16,
  localparam int PASS_W     = $clog2(MAX_PASSES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic scan_begin,
  input  logic hit,
  input  logic pass_end,
  output logic found_any,
  output logic last_pass
);

  logic              found_q;
  logic [PASS_W-1:0] npass_q;

  assign found_any = found_q | hit;
  assign last_pass = (npass_q == PASS_W'(MAX_PASSES - 1));

  always_ff @(posedge clk) begin
    if (rst || scan_begin) begin
      found_q <= 1'b0;
      npass_q <= '0;
    end else begin
      if (pass_end)  found_q <= 1'b0;
      else if (hit)  found_q <= 1'b1;
      if (pass_end && found_any) npass_q <= npass_q + PASS_W'(1);
    end
  end

endmodule

// File: rtl/lamscan_out.sv
module lamscan_out #(
  parameter int DATA_W = 24,
  parameter int STN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STN_W-1:0]  stn_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [STN_W-1:0]  stn_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      stn_o   <= '0;
    end else begin
      valid_o <= capture;
      if (capture) begin
        data_o <= data_i;
        stn_o  <= stn_i;
      end
    end
  end

endmodule

// File: rtl/lamscan_ctrl.sv
module lamscan_ctrl
  import lamscan_pkg::*;
#(
  parameter  int NUM_STATIONS = 23,
  parameter  int DATA_W       = 24,
  parameter  int MAX_PASSES   = 16,
  parameter  int SYNC_STAGES  = 2,
  localparam int STN_W        = $clog2(NUM_STATIONS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NUM_STATIONS-1:0] lam_i,
  output logic                    rd_req,
  output logic [STN_W-1:0]        rd_stn,
  input  logic                    rd_done,
  input  logic [DATA_W-1:0]       rd_data,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data,
  output logic [STN_W-1:0]        out_stn,
  output logic                    busy,
  output logic                    eob_irq,
  output logic                    timeout
);

  localparam logic [STN_W-1:0] TOP_STN = STN_W'(NUM_STATIONS);
  localparam logic [STN_W-1:0] BOT_STN = STN_W'(1);

  scan_state_e             state_q, state_d;
  logic [STN_W-1:0]        ptr_q, ptr_d;
  logic                    req_q, req_d;
  logic                    eob_q, eob_d;
  logic                    to_q, to_d;
  logic [NUM_STATIONS-1:0] lam_s;
  logic [STN_W-1:0]        scan_idx;
  logic                    pending;
  logic                    read_fin;
  logic                    advance;
  logic                    pass_end;
  logic                    scan_begin;
  logic                    found_any;
  logic                    last_pass;

  lamscan_sync #(
    .WIDTH  (NUM_STATIONS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (lam_i),
    .sync_o  (lam_s)
  );

  assign scan_idx   = ptr_q - BOT_STN;
  assign pending    = lam_s[scan_idx];
  assign read_fin   = (state_q == ST_READ) && rd_done;
  assign advance    = ((state_q == ST_SCAN) && !pending) || read_fin;
  assign pass_end   = advance && (ptr_q == BOT_STN);
  assign scan_begin = (state_q == ST_IDLE) && start;

  lamscan_pass_ctrl #(
    .MAX_PASSES (MAX_PASSES)
  ) i_pass (
    .clk        (clk),
    .rst        (rst),
    .scan_begin (scan_begin),
    .hit        (read_fin),
    .pass_end   (pass_end),
    .found_any  (found_any),
    .last_pass  (last_pass)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    req_d   = req_q;
    eob_d   = 1'b0;
    to_d    = to_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SCAN;
          ptr_d   = TOP_STN;
          to_d    = 1'b0;
        end
      end
      ST_SCAN: begin
        if (pending) begin
          state_d = ST_READ;
          req_d   = 1'b1;
        end
      end
      ST_READ: begin
        if (rd_done) begin
          state_d = ST_SCAN;
          req_d   = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (advance) begin
      if (ptr_q == BOT_STN) begin
        if (!found_any) begin
          state_d = ST_IDLE;
          eob_d   = 1'b1;
        end else if (last_pass) begin
          state_d = ST_IDLE;
          to_d    = 1'b1;
        end else begin
          ptr_d = TOP_STN;
        end
      end else begin
        ptr_d = ptr_q - BOT_STN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= TOP_STN;
      req_q   <= 1'b0;
      eob_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      req_q   <= req_d;
      eob_q   <= eob_d;
      to_q    <= to_d;
    end
  end

  lamscan_out #(
    .DATA_W (DATA_W),
    .STN_W  (STN_W)
  ) i_out (
    .clk     (clk),
    .rst     (rst),
    .capture (read_fin),
    .data_i  (rd_data),
    .stn_i   (ptr_q),
    .valid_o (out_valid),
    .data_o  (out_data),
    .stn_o   (out_stn)
  );

  assign rd_req  = req_q;
  assign rd_stn  = ptr_q;
  assign busy    = (state_q != ST_IDLE);
  assign eob_irq = eob_q;
  assign timeout = to_q;

endmodule

// File: rtl/lamscan_chk.sv
module lamscan_chk #(
  parameter int NUM_STATIONS = 23,
  parameter int DATA_W       = 24,
  parameter int STN_W        = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_req,
  input logic [STN_W-1:0]  rd_stn,
  input logic              rd_done,
  input logic [DATA_W-1:0] rd_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [STN_W-1:0]  out_stn,
  input logic              busy,
  input logic              eob_irq,
  input logic              timeout
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !rd_req && !out_valid && !eob_irq && !timeout)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_done) |=> (rd_req && $stable(rd_stn))); // R3

  AST_REQ_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (busy && rd_stn != '0 && rd_stn <= STN_W'(NUM_STATIONS))); // R3

  AST_OUT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_req && rd_done)); // R4

  AST_OUT_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_stn == $past(rd_stn) && out_data == $past(rd_data))); // R4

  AST_EOB_PULSE: assert property (@(posedge clk) disable iff (rst)
    eob_irq |=> !eob_irq); // R6

  AST_EOB_IDLE: assert property (@(posedge clk) disable iff (rst)
    eob_irq |-> (!busy && !timeout)); // R6

  AST_TIMEOUT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> (!busy && !eob_irq)); // R7

  AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (timeout && !start) |=> timeout); // R7

endmodule

bind lamscan_ctrl lamscan_chk #(
  .NUM_STATIONS (NUM_STATIONS),
  .DATA_W       (DATA_W),
  .STN_W        (STN_W)
) i_lamscan_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .rd_req    (rd_req),
  .rd_stn    (rd_stn),
  .rd_done   (rd_done),
  .rd_data   (rd_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_stn   (out_stn),
  .busy      (busy),
  .eob_irq   (eob_irq),
  .timeout   (timeout)
);

// File: tb/test_lamscan_ctrl.sv
module test_lamscan_ctrl;
  localparam int NS = 23;
  localparam int DW = 24;
  localparam int MP = 16;
  localparam int LIM = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NS-1:0] lam = '0;
  logic          rd_done = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          rd_req, out_valid, busy, eob_irq, timeout;
  logic [4:0]    rd_stn, out_stn;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  lamscan_ctrl #(.NUM_STATIONS(NS), .DATA_W(DW), .MAX_PASSES(MP)) i_lamscan_ctrl (
    .clk(clk), .rst(rst), .start(start), .lam_i(lam), .rd_req(rd_req), .rd_stn(rd_stn),
    .rd_done(rd_done), .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data),
    .out_stn(out_stn), .busy(busy), .eob_irq(eob_irq), .timeout(timeout));

  int checks = 0, fails = 0, cycles = 0;
  int cnt [1:NS];
  int exp_stn [LIM];
  logic [DW-1:0] eng_data [LIM];
  int exp_n = 0, eng_n = 0, out_n = 0, eob_seen = 0, dly = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int max_count();
    int m = 0;
    for (int s = 1; s <= NS; s++) if (cnt[s] > m) m = cnt[s];
    return m;
  endfunction

  // Dataway engine model: answers after 0..3 cycles, retires one word of the station.
  always @(negedge clk) begin
    if (rst) begin
      rd_done = 1'b0;
      dly = 0;
    end else if (rd_done) begin
      rd_done = 1'b0;
    end else if (rd_req) begin
      if (dly > 0) dly--;
      else begin
        if (rd_stn >= 1 && rd_stn <= NS) begin
          chk(cnt[rd_stn] > 0, "R3", "read of non-pending station", int'(rd_stn), 0);
          if (cnt[rd_stn] > 0) cnt[rd_stn]--;
          if (cnt[rd_stn] == 0) lam[rd_stn-1] = 1'b0;
        end else chk(1'b0, "R3", "station out of range", int'(rd_stn), 1);
        rd_data = DW'($urandom);
        if (eng_n < LIM) eng_data[eng_n] = rd_data;
        eng_n++;
        rd_done = 1'b1;
        dly = $urandom % 4;
      end
    end
  end

  // Output monitor: order (R2, R5) and payload (R4).
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (out_n < exp_n && out_n < LIM) begin
          chk(out_stn == exp_stn[out_n], "R2/R5", "station order", int'(out_stn), exp_stn[out_n]);
          chk(out_data == eng_data[out_n], "R4", "word payload", int'(out_data), int'(eng_data[out_n]));
        end else chk(1'b0, "R3", "unexpected extra word", out_n, exp_n);
        out_n++;
      end
      if (eob_irq) eob_seen++;
    end
  end

  task automatic run_scn(string name, bit restart_mid);
    int mx, g;
    bit exp_to;
    mx = max_count();
    exp_to = (mx >= MP);
    exp_n = 0; out_n = 0; eng_n = 0; eob_seen = 0;
    for (int p = 1; p <= MP; p++)
      for (int s = NS; s >= 1; s--)
        if (cnt[s] >= p && exp_n < LIM) begin exp_stn[exp_n] = s; exp_n++; end
    for (int s = 1; s <= NS; s++) lam[s-1] = (cnt[s] > 0);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2", {name, " busy after start"}, int'(busy), 1);
    if (restart_mid) begin
      repeat (30) @(negedge clk);
      chk(busy, "R9", {name, " still busy at second start"}, int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    g = 0;
    while (busy && g < 20000) begin @(negedge clk); g++; end
    @(negedge clk);
    chk(out_n == exp_n, "R3", {name, " word count"}, out_n, exp_n);
    chk(timeout == exp_to, "R7", {name, " timeout flag"}, int'(timeout), int'(exp_to));
    chk(eob_seen == (exp_to ? 0 : 1), "R6", {name, " end-of-block pulses"}, eob_seen, exp_to ? 0 : 1);
    for (int s = 1; s <= NS; s++) cnt[s] = 0;
    lam = '0;
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd20240517));
    for (int s = 1; s <= NS; s++) cnt[s] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !out_valid && !eob_irq && !timeout, "R1", "outputs in reset",
        int'({busy, rd_req, out_valid, eob_irq, timeout}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rd_req && !out_valid && !eob_irq && !timeout, "R1", "outputs after reset",
        int'({busy, rd_req, out_valid, eob_irq, timeout}), 0);

    // R10: empty crate, scan rate of one station per clock.
    repeat (3) @(negedge clk);
    eob_seen = 0; out_n = 0; exp_n = 0;
    start = 1'b1;
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (eob_irq) break;
    end
    chk(cyc == NS + 1, "R10", "empty-crate end-of-block latency", cyc, NS + 1);
    @(negedge clk);
    chk(out_n == 0, "R10", "no words from empty crate", out_n, 0);

    // R8: request raised together with start misses station 23 in the first pass.
    repeat (3) @(negedge clk);
    eob_seen = 0; out_n = 0; exp_n = 0;
    start = 1'b1;
    lam[NS-1] = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lam[NS-1] = 1'b0;
    cyc = 0;
    while (busy && cyc < 200) begin @(negedge clk); cyc++; end
    @(negedge clk);
    chk(out_n == 0, "R8", "late request not read", out_n, 0);
    chk(eob_seen == 1, "R8", "end-of-block after missed request", eob_seen, 1);

    // Directed: lone station 1 with three words (wrap from bottom of pass, R5).
    cnt[1] = 3;
    run_scn("station1", 1'b0);
    // Directed: every station once, back-to-back reads.
    for (int s = 1; s <= NS; s++) cnt[s] = 1;
    run_scn("full", 1'b0);
    // Directed: one below the pass limit ends normally.
    cnt[7] = MP - 1; cnt[20] = 2; cnt[12] = 1;
    run_scn("below_limit", 1'b0);
    // Directed: reaching the pass limit times out.
    cnt[7] = MP; cnt[20] = 2; cnt[3] = 5;
    run_scn("at_limit", 1'b0);
    // R9: second start mid-scan is ignored.
    cnt[23] = 3; cnt[10] = 2; cnt[5] = 1;
    run_scn("restart_ignored", 1'b1);
    // Random crates.
    for (int r = 0; r < 8; r++) begin
      for (int s = 1; s <= NS; s++) cnt[s] = ($urandom % 2 == 0) ? 0 : int'($urandom % 4);
      run_scn("random", 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule